// File: doc/BRIEF.md
# Streaming Vector Dot/Cross Product Engine

This block computes products of pairs of signed vectors that arrive as word streams. Operand A and operand B each have their own input queue. Results go out through one output queue. A controller reads one word from each input queue per step, computes, and writes the result words. It supports two operations. The dot product accumulates one signed product per band into a wide register and writes a single word. The cross product works on three-component vectors and writes three words.

Software or a stream mover fills the two input queues. It sets the operation code and band count, then pulses `start`. The busy, done and error outputs report progress. The configuration is checked when `start` arrives. A configuration that is not supported raises the error output and runs nothing, and it leaves every queue untouched. The controller stalls without losing data when an input queue runs dry or the output queue fills.

Top module: `vec_prod_engine`

## Requirements
- R1: After reset, busy, done and error are 0, the result queue reports empty, and neither input queue reports full.
- R2: Operation code 0 (dot) with band count N consumes N operand pairs. It writes one 40-bit word: the two's-complement sum of the N signed 16-bit products, sign-extended.
- R3: Operation code 1 (cross) with band count 3 consumes pairs a0/b0, a1/b1 and a2/b2. It writes three words in this order: a1*b2-a2*b1, then a2*b0-a0*b2, then a0*b1-a1*b0, each sign-extended to 40 bits.
- R4: A start with operation code 2 or 3, a band count of 0, a band count above 256, or a cross with any band count other than 3 sets error to 1 one cycle later. It leaves busy and done at 0 and consumes and writes no words.
- R5: Any start accepted while idle clears done and error in the next cycle.
- R6: A start that arrives while busy is 1 has no effect. The running job finishes alone and no further job follows.
- R7: While an input queue is empty or the output queue is full, the controller holds its position, and no operand or result is lost or duplicated.
- R8: Done rises in the cycle after the last result word is written, and busy falls at the same moment. With operands already queued, a dot job of N bands shows done N+1 cycles after the start edge.
- R9: Each queue holds 16 words and presents its head word without a read-latency cycle. Full is set after 16 writes. A write while full and a read while empty are ignored.
- R10: The dot accumulator does not overflow for up to 256 bands of extreme operands. For example, 256 products of -32768*-32768 give 2^38.
- R11: With operands already queued and the output not full, a cross job shows done exactly 6 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op_code | input | 2 | 0 = dot product, 1 = cross product, others invalid |
| band_count | input | 9 | Bands per vector |
| a_wr_en | input | 1 | Push into operand A queue |
| a_wr_data | input | 16 | Signed operand A word |
| a_full | output | 1 | Operand A queue full |
| b_wr_en | input | 1 | Push into operand B queue |
| b_wr_data | input | 16 | Signed operand B word |
| b_full | output | 1 | Operand B queue full |
| res_rd_en | input | 1 | Pop the result queue head |
| res_rd_data | output | 40 | Result queue head word |
| res_empty | output | 1 | Result queue empty |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job completed |
| error | output | 1 | Last start carried an invalid configuration |

## Verification
Two things can happen in the same cycle on the result queue: the engine writes a result word, and the consumer pops the head word. The same overlap happens on the input side, where the engine consumes an operand pair while the producer pushes the next one. The bench provokes both overlaps. It drains results every cycle or every other cycle, and sometimes holds the read enable high even when the queue is empty. It also feeds operands after `start` with gaps so that jobs stall mid-stream. Every popped word is compared in the cycle it appears against a queue of words computed in the bench from the operand lists. The cycle counts from start to done are compared against the N+1 and 6 figures.

// File: rtl/vpe_pkg.sv
package vpe_pkg;

  localparam int OP_W = 2;
  localparam logic [OP_W-1:0] OP_DOT   = 2'd0;
  localparam logic [OP_W-1:0] OP_CROSS = 2'd1;

  localparam int CROSS_LEN = 3;
  localparam int SEL_W     = 2;
  localparam logic [SEL_W-1:0] SEL_ACC = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DOT_RD,
    ST_DOT_WR,
    ST_X_RD,
    ST_X_WR
  } vpe_state_e;

  // configuration legality, judged once at launch
  function automatic logic cfg_ok(input logic [OP_W-1:0] op,
                                  input int unsigned bands,
                                  input int unsigned max_bands);
    case (op)
      OP_DOT:   return (bands != 0) && (bands <= max_bands);
      OP_CROSS: return bands == CROSS_LEN;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vpe_fifo.sv
module vpe_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr;
  logic [AW:0]      rd_ptr;
  logic             wr_fire;
  logic             rd_fire;

  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign empty   = (wr_ptr == rd_ptr);
  assign wr_fire = wr_en && !full;
  assign rd_fire = rd_en && !empty;

  // head word visible with no read latency
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr))); // R9
  AST_FIFO_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_ptr))); // R9
  AST_FIFO_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_en) |=> $stable(rd_data)); // R9

endmodule

// File: rtl/vpe_datapath.sv
module vpe_datapath import vpe_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mac_en,
  input  logic              cap_en,
  input  logic [SEL_W-1:0]  cap_idx,
  input  logic [SEL_W-1:0]  word_sel,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [ACC_W-1:0]  res
);

  localparam int PROD_W = 2 * DATA_W;

  // full product, sign-extended to the accumulator width
  function automatic logic signed [ACC_W-1:0] prod_ext(input logic signed [DATA_W-1:0] x,
                                                       input logic signed [DATA_W-1:0] y);
    logic signed [PROD_W-1:0] p;
    p = x * y;
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  // one cross component: x1*y2 - x2*y1
  function automatic logic signed [ACC_W-1:0] cross_term(input logic signed [DATA_W-1:0] x1,
                                                         input logic signed [DATA_W-1:0] y2,
                                                         input logic signed [DATA_W-1:0] x2,
                                                         input logic signed [DATA_W-1:0] y1);
    return prod_ext(x1, y2) - prod_ext(x2, y1);
  endfunction

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [DATA_W-1:0] a_v [CROSS_LEN];
  logic signed [DATA_W-1:0] b_v [CROSS_LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (mac_en) acc_q <= acc_q + prod_ext(a_in, b_in);
  end

  for (genvar i = 0; i < CROSS_LEN; i++) begin : g_lane
    logic signed [DATA_W-1:0] a_r;
    logic signed [DATA_W-1:0] b_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        b_r <= '0;
      end else if (cap_en && (cap_idx == SEL_W'(i))) begin
        a_r <= a_in;
        b_r <= b_in;
      end
    end
    assign a_v[i] = a_r;
    assign b_v[i] = b_r;
  end

  always_comb begin
    case (word_sel)
      2'd0:    res = cross_term(a_v[1], b_v[2], a_v[2], b_v[1]);
      2'd1:    res = cross_term(a_v[2], b_v[0], a_v[0], b_v[2]);
      2'd2:    res = cross_term(a_v[0], b_v[1], a_v[1], b_v[0]);
      default: res = acc_q;
    endcase
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0)); // R2
  AST_NO_MAC_AND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mac_en && cap_en)); // R3

endmodule

// File: rtl/vpe_fsm.sv
module vpe_fsm import vpe_pkg::*; #(
  parameter int BAND_W    = 9,
  parameter int MAX_BANDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_code,
  input  logic [BAND_W-1:0] band_count,
  input  logic              a_empty,
  input  logic              b_empty,
  input  logic              r_full,
  output logic              pop,
  output logic              push,
  output logic              clr,
  output logic              mac_en,
  output logic              cap_en,
  output logic [SEL_W-1:0]  cap_idx,
  output logic [SEL_W-1:0]  word_sel,
  output logic              busy,
  output logic              done,
  output logic              error
);

  vpe_state_e        state_q;
  logic [BAND_W-1:0] cnt_q;
  logic [BAND_W-1:0] bands_q;
  logic              busy_q;
  logic              done_q;
  logic              err_q;

  logic pair_ok;
  logic rd_state;
  logic wr_state;
  logic launch;
  logic cfg_good;
  logic last_band;
  logic last_lane;

  always_comb begin
    pair_ok   = !a_empty && !b_empty;
    rd_state  = (state_q == ST_DOT_RD) || (state_q == ST_X_RD);
    wr_state  = (state_q == ST_DOT_WR) || (state_q == ST_X_WR);
    pop       = rd_state && pair_ok;
    push      = wr_state && !r_full;
    mac_en    = pop && (state_q == ST_DOT_RD);
    cap_en    = pop && (state_q == ST_X_RD);
    cap_idx   = cnt_q[SEL_W-1:0];
    word_sel  = (state_q == ST_X_WR) ? cnt_q[SEL_W-1:0] : SEL_ACC;
    launch    = (state_q == ST_IDLE) && start;
    cfg_good  = cfg_ok(op_code, 32'(band_count), MAX_BANDS);
    clr       = launch && cfg_good;
    last_band = (cnt_q == bands_q - BAND_W'(1));
    last_lane = (cnt_q == BAND_W'(CROSS_LEN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bands_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            done_q <= 1'b0;
            err_q  <= !cfg_good;
            if (cfg_good) begin
              busy_q  <= 1'b1;
              cnt_q   <= '0;
              bands_q <= band_count;
              state_q <= (op_code == OP_CROSS) ? ST_X_RD : ST_DOT_RD;
            end
          end
        end
        ST_DOT_RD: begin
          if (pop) begin
            if (last_band) begin
              cnt_q   <= '0;
              state_q <= ST_DOT_WR;
            end else begin
              cnt_q <= cnt_q + BAND_W'(1);
            end
          end
        end
        ST_DOT_WR: begin
          if (push) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_X_RD: begin
          if (pop) begin
            if (last_lane) begin
              cnt_q   <= '0;
              state_q <= ST_X_WR;
            end else begin
              cnt_q <= cnt_q + BAND_W'(1);
            end
          end
        end
        ST_X_WR: begin
          if (push) begin
            if (last_lane) begin
              cnt_q   <= '0;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + BAND_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign error = err_q;

  AST_IN_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_state && !pair_ok) |=> $stable(cnt_q)); // R7
  AST_OUT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_state && r_full) |=> (busy_q && $stable(cnt_q))); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q)); // R8
  AST_DONE_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(push)); // R8
  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_q && !pop && !push)); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !push) |=> busy_q); // R6
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(start)); // R5

endmodule

// File: rtl/vec_prod_engine.sv
module vec_prod_engine import vpe_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int MAX_BANDS  = 256,
  parameter int FIFO_DEPTH = 16,
  localparam int BAND_W = $clog2(MAX_BANDS + 1),
  localparam int ACC_W  = 2 * DATA_W + $clog2(MAX_BANDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_code,
  input  logic [BAND_W-1:0] band_count,
  input  logic              a_wr_en,
  input  logic [DATA_W-1:0] a_wr_data,
  output logic              a_full,
  input  logic              b_wr_en,
  input  logic [DATA_W-1:0] b_wr_data,
  output logic              b_full,
  input  logic              res_rd_en,
  output logic [ACC_W-1:0]  res_rd_data,
  output logic              res_empty,
  output logic              busy,
  output logic              done,
  output logic              error
);

  logic [DATA_W-1:0] a_head;
  logic [DATA_W-1:0] b_head;
  logic              a_empty;
  logic              b_empty;
  logic              r_full;
  logic              pop;
  logic              push;
  logic              clr;
  logic              mac_en;
  logic              cap_en;
  logic [SEL_W-1:0]  cap_idx;
  logic [SEL_W-1:0]  word_sel;
  logic [ACC_W-1:0]  res_word;

  vpe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_a_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(a_wr_en), .wr_data(a_wr_data),
    .rd_en(pop), .rd_data(a_head),
    .full(a_full), .empty(a_empty)
  );

  vpe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_b_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(b_wr_en), .wr_data(b_wr_data),
    .rd_en(pop), .rd_data(b_head),
    .full(b_full), .empty(b_empty)
  );

  vpe_fsm #(.BAND_W(BAND_W), .MAX_BANDS(MAX_BANDS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(start), .op_code(op_code), .band_count(band_count),
    .a_empty(a_empty), .b_empty(b_empty), .r_full(r_full),
    .pop(pop), .push(push), .clr(clr),
    .mac_en(mac_en), .cap_en(cap_en),
    .cap_idx(cap_idx), .word_sel(word_sel),
    .busy(busy), .done(done), .error(error)
  );

  vpe_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .clr(clr), .mac_en(mac_en), .cap_en(cap_en),
    .cap_idx(cap_idx), .word_sel(word_sel),
    .a_in(a_head), .b_in(b_head),
    .res(res_word)
  );

  vpe_fifo #(.WIDTH(ACC_W), .DEPTH(FIFO_DEPTH)) u_r_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_data(res_word),
    .rd_en(res_rd_en), .rd_data(res_rd_data),
    .full(r_full), .empty(res_empty)
  );

  AST_POP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (!a_empty && !b_empty)); // R7

endmodule

// File: tb/vec_prod_engine_bench.sv
module vec_prod_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_code = '0;
  logic [8:0]  band_count = '0;
  logic        a_wr_en = 1'b0;
  logic [15:0] a_wr_data = '0;
  logic        a_full;
  logic        b_wr_en = 1'b0;
  logic [15:0] b_wr_data = '0;
  logic        b_full;
  logic        res_rd_en = 1'b0;
  logic [39:0] res_rd_data;
  logic        res_empty;
  logic        busy;
  logic        done;
  logic        error;

  vec_prod_engine u_vec_prod_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .band_count(band_count),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_full(a_full),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_full(b_full),
    .res_rd_en(res_rd_en), .res_rd_data(res_rd_data), .res_empty(res_empty),
    .busy(busy), .done(done), .error(error)
  );

  always #10 clk = ~clk;

  int          n_chk = 0;
  int          n_err = 0;
  logic [39:0] exp_q[$];
  int          qa[$];
  int          qb[$];
  string       cur_req = "R2";
  int          drain_mode = 0;
  bit          phase = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // consumer and per-clock comparison against the reference queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        bit take;
        take = (drain_mode == 1) || (drain_mode == 3) || (drain_mode == 2 && phase);
        phase = !phase;
        if (take && !res_empty) begin
          if (exp_q.size() == 0) chk({cur_req, " unexpected word"}, res_rd_data, 64'hDEAD);
          else chk({cur_req, " word"}, res_rd_data, exp_q.pop_front());
        end
        res_rd_en = (drain_mode == 3) ? 1'b1 : (take && !res_empty);
        if (busy && done) chk("R8 busy/done overlap", 1, 0);
        if (error && busy) chk("R4 error while busy", 1, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  task automatic load_pair(input int a, input int b);
    while (a_full || b_full) tick();
    a_wr_en = 1'b1; a_wr_data = 16'(a);
    b_wr_en = 1'b1; b_wr_data = 16'(b);
    tick();
    a_wr_en = 1'b0; b_wr_en = 1'b0;
  endtask

  task automatic do_start(input logic [1:0] op, input int bands);
    op_code = op; band_count = 9'(bands); start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, input int exp_lat);
    int k = 0;
    while (!done && k < 3000) begin tick(); k++; end
    chk({req, " done"}, done, 1);
    chk({req, " busy low at done"}, busy, 0);
    if (exp_lat >= 0) chk({req, " latency"}, k, exp_lat);
    if (drain_mode != 0) begin
      k = 0;
      while ((exp_q.size() != 0 || !res_empty) && k < 3000) begin tick(); k++; end
      chk({req, " all words out"}, exp_q.size(), 0);
    end
  endtask

  // mode 0: preload, 1: stream after start with gaps, 2: operands already queued
  task automatic run_dot(input string req, input int mode, input int exp_lat);
    longint s = 0;
    foreach (qa[i]) s += longint'(qa[i]) * longint'(qb[i]);
    exp_q.push_back(s[39:0]);
    cur_req = req;
    if (mode == 0) foreach (qa[i]) load_pair(qa[i], qb[i]);
    do_start(2'd0, qa.size());
    if (mode == 1) foreach (qa[i]) begin load_pair(qa[i], qb[i]); tick(); end
    wait_done(req, exp_lat);
  endtask

  task automatic run_cross(input string req, input bit wait_it);
    longint c0, c1, c2;
    c0 = longint'(qa[1]) * qb[2] - longint'(qa[2]) * qb[1];
    c1 = longint'(qa[2]) * qb[0] - longint'(qa[0]) * qb[2];
    c2 = longint'(qa[0]) * qb[1] - longint'(qa[1]) * qb[0];
    exp_q.push_back(c0[39:0]); exp_q.push_back(c1[39:0]); exp_q.push_back(c2[39:0]);
    cur_req = req;
    for (int i = 0; i < 3; i++) load_pair(qa[i], qb[i]);
    do_start(2'd1, 3);
    if (wait_it) wait_done(req, 6);
  endtask

  task automatic try_bad(input string req, input logic [1:0] op, input int bands);
    do_start(op, bands);
    chk({req, " error set"}, error, 1);
    chk({req, " busy stays low"}, busy, 0);
    chk({req, " done low"}, done, 0);
    chk({req, " no result"}, res_empty, 1);
  endtask

  initial begin
    repeat (4) tick();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 res empty", res_empty, 1);
    chk("R1 a not full", a_full, 0);
    chk("R1 b not full", b_full, 0);

    drain_mode = 1;
    // R2 / R8: preloaded dot, latency N+1
    qa = '{3, -7, 100, -32768, 12}; qb = '{-2, -5, 300, 2, 32767};
    run_dot("R2 dot5", 0, 6);
    // R3 / R11: preloaded cross, latency 6
    qa = '{1, 2, 3}; qb = '{4, 5, 6};
    run_cross("R3 cross small", 1);
    qa = '{-32768, 32767, -32768}; qb = '{32767, -32768, -32768};
    run_cross("R11 cross extreme", 1);

    // R7: streamed dot longer than queue depth, consumer every other cycle
    drain_mode = 2;
    qa.delete(); qb.delete();
    for (int i = 0; i < 20; i++) begin qa.push_back(i * 1000 - 9000); qb.push_back(7 - i * 311); end
    run_dot("R7 dot stream", 1, -1);

    // R10: 256 extreme bands; read enable held high even when empty (R9)
    drain_mode = 3;
    qa.delete(); qb.delete();
    for (int i = 0; i < 256; i++) begin qa.push_back(-32768); qb.push_back(-32768); end
    run_dot("R10 dot 256", 1, -1);
    chk("R10 value 2^38", longint'(1) << 38, 64'h40_0000_0000);

    // R7: output queue fills during the sixth cross job
    drain_mode = 0;
    for (int j = 0; j < 6; j++) begin
      qa = '{j + 1, -j, 2 * j}; qb = '{5 - j, j * 3, -7};
      run_cross("R7 out full", j < 5);
    end
    repeat (20) tick();
    chk("R7 stalled busy", busy, 1);
    chk("R7 stalled no done", done, 0);
    chk("R7 results held", res_empty, 0);
    drain_mode = 1;
    wait_done("R7 out full drain", -1);

    // R4 / R5: invalid configurations leave the queued pair untouched
    load_pair(5, -3);
    try_bad("R4 op2", 2'd2, 3);
    try_bad("R4 op3", 2'd3, 1);
    try_bad("R4 dot zero", 2'd0, 0);
    try_bad("R4 dot 300", 2'd0, 300);
    try_bad("R4 cross 4", 2'd1, 4);
    qa = '{5}; qb = '{-3};
    exp_q.push_back(40'hFF_FFFF_FFF1);
    cur_req = "R5 after error";
    do_start(2'd0, 1);
    chk("R5 error cleared", error, 0);
    wait_done("R5 after error", 2);
    do_start(2'd2, 1);
    chk("R5 done cleared by start", done, 0);

    // R6: start while busy is ignored
    qa = '{10, -20, 30, -40}; qb = '{3, 3, -3, -3};
    exp_q.push_back(40'h00_0000_0000);
    cur_req = "R6 ignored start";
    load_pair(10, 3); load_pair(-20, 3);
    do_start(2'd0, 4);
    repeat (3) tick();
    do_start(2'd1, 3);
    load_pair(30, -3); load_pair(-40, -3);
    wait_done("R6 ignored start", -1);
    repeat (10) tick();
    chk("R6 no second job busy", busy, 0);
    chk("R6 no extra word", res_empty, 1);

    // R9: queue depth, write while full ignored
    qa.delete(); qb.delete();
    for (int i = 0; i < 16; i++) begin
      a_wr_en = 1'b1; a_wr_data = 16'(i * 3 - 20); qa.push_back(i * 3 - 20);
      tick();
    end
    a_wr_en = 1'b0;
    chk("R9 full after 16", a_full, 1);
    a_wr_en = 1'b1; a_wr_data = 16'(999);
    tick();
    a_wr_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      b_wr_en = 1'b1; b_wr_data = 16'(1); qb.push_back(1);
      tick();
    end
    b_wr_en = 1'b0;
    run_dot("R9 sixteen queued", 2, 17);
    chk("R9 a drained", a_full, 0);
    qa = '{7}; qb = '{1};
    run_dot("R9 dropped write", 0, 2);

    repeat (4) tick();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule